// File: doc/BRIEF.md
# DMA Channel Register and Interrupt-Coalescing Unit

This block is the register bank for both channels of a two-channel scatter-gather DMA. A simple 32-bit register bus reaches it. Every channel has a control word, a status word, a current-descriptor pointer and a tail-descriptor pointer. The block passes run, soft-reset and start commands to a descriptor engine that lives elsewhere. That engine reports completed frames and its halted and idle conditions back to this block as one-cycle pulses.

Each channel merges its completion events into a single interrupt line in two ways. A completion counter raises the completion interrupt once every N frames, where N is the threshold field of the control word. A delay timer raises the delay interrupt when no frame has completed for a programmed number of timer ticks. One tick lasts `PRESC` core clocks. The live counter and timer values appear in the upper bits of the status word, so software can see how far each channel has progressed toward its next interrupt.

The reset input is asserted asynchronously and released through a two-stage synchronizer. The core registers therefore leave reset on the second clock edge after `rst_n` rises.

Top module: `dmac_regs`

## Requirements
- R1: Channel select is (byte address / 0x30) modulo 2. The offset inside a channel is the byte address modulo 0x30. Offset 0x00 is control, 0x04 is status, 0x08 is current descriptor and 0x10 is tail descriptor. Any other offset reads 0 and ignores writes. The two channels hold independent state.
- R2: Control bit 1 always reads 1, whatever value is written. Control bit 0 (run) drives the `run` output of its channel.
- R3: After reset, control reads 0x0001_0002 (threshold field 23:16 = 1), status reads 0x0001_0001 (halted bit 0, live count 1), and `irq`, `run`, `soft_rst` and `tx_start` are low.
- R4: A control write with bit 2 set, or any control write while bit 2 is still set, does three things: it loads control with threshold 1 and bit 2 set, it sets status to halted only, and it leaves run low. Bit 2 drives `soft_rst` and stays set until control is next read. A control read returns bit 2 as 0 and clears it.
- R5: A control write with bit 0 = 1 while soft reset is not active clears halted (status bit 0) and idle (status bit 1).
- R6: Status bits 14:12 are pending interrupts: bit 12 is the completion interrupt and bit 13 is the delay interrupt. Writing 1 to one of these bits clears it. Writing 0 leaves it unchanged.
- R7: `irq` of a channel is high whenever (status[14:12] AND control[14:12]) is nonzero. A pending bit whose enable is 0 does not raise `irq`.
- R8: Each `frame_done` pulse decrements a completion counter, which wraps modulo 256. When the counter reaches zero, status bit 12 is set and the counter reloads from control[23:16]. Status bits 23:16 show the live counter.
- R9: A `frame_done` pulse when control[31:24] is nonzero loads the delay timer with that value. While nonzero, the timer decrements once every `PRESC` clocks. When it reaches zero, status bit 13 is set and the completion counter reloads. Status bits 31:24 show the live timer.
- R10: Any control write reloads the completion counter from the threshold field being written.
- R11: A tail-descriptor write clears idle. On channel 0 only, it produces a one-cycle `tx_start` pulse in the cycle after the write.
- R12: An `eng_halt` pulse sets the halted flag and an `eng_idle` pulse sets the idle flag of its channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe, one cycle per access |
| bus_rd | input | 1 | Register read strobe, one cycle per access |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current address (combinational) |
| frame_done | input | 2 | Per-channel frame-complete pulse from the engine |
| eng_halt | input | 2 | Per-channel pulse that sets halted |
| eng_idle | input | 2 | Per-channel pulse that sets idle |
| irq | output | 2 | Per-channel interrupt |
| run | output | 2 | Per-channel run command |
| soft_rst | output | 2 | Per-channel soft-reset command |
| tx_start | output | 1 | Start request to the channel 0 engine |

## Verification
The properties assume that `bus_wr` and `bus_rd` are never high in the same cycle. They also assume that no access arrives while the synchronizer still holds the core in reset, and that the engine does not report a halt in the same cycle as a run write. The stimulus drives one access at a time, at the falling clock edge. It waits three cycles after reset is released before the first access, and it never pulses `frame_done` or the engine flags in the same cycle as a bus access. Timer checks leave enough idle cycles for the prescaled countdown to finish before status is read.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
  localparam int CH_N      = 2;
  localparam int WIN_BYTES = 48;
  localparam int OFS_W     = 6;
  localparam int CNT_W     = 8;

  localparam logic [OFS_W-1:0] OFS_CTRL = 6'h00;
  localparam logic [OFS_W-1:0] OFS_STAT = 6'h04;
  localparam logic [OFS_W-1:0] OFS_CUR  = 6'h08;
  localparam logic [OFS_W-1:0] OFS_TAIL = 6'h10;

  localparam logic [31:0] CTRL_RST  = 32'h0001_0002;
  localparam logic [31:0] CTRL_SRST = 32'h0001_0006;

  typedef struct packed {
    logic wr_ctrl;
    logic wr_stat;
    logic wr_cur;
    logic wr_tail;
    logic rd_ctrl;
  } acc_t;
endpackage

// File: rtl/dmac_coalesce.sv
module dmac_coalesce #(
  parameter int PRESC = 4,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reload,
  input  logic             done,
  input  logic [CNT_W-1:0] thr,
  input  logic [CNT_W-1:0] dly,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] tmr,
  output logic             ioc_evt,
  output logic             dly_evt
);
  localparam int PRESC_W = (PRESC > 1) ? $clog2(PRESC) : 1;
  localparam logic [PRESC_W-1:0] PRE_LAST = PRESC_W'(PRESC - 1);

  logic [CNT_W-1:0]   cnt_n, tmr_n;
  logic [PRESC_W-1:0] pre_q, pre_n;
  logic               tick;

  always_comb begin
    cnt_n   = cnt;
    tmr_n   = tmr;
    ioc_evt = 1'b0;
    dly_evt = 1'b0;
    tick    = (tmr != '0) && (pre_q == PRE_LAST);
    pre_n   = (tmr == '0 || pre_q == PRE_LAST) ? '0 : pre_q + 1'b1;
    if (tick) begin
      tmr_n = tmr - 1'b1;
      if (tmr == CNT_W'(1)) begin
        dly_evt = 1'b1;
        cnt_n   = thr;
      end
    end
    if (done) begin
      if (dly != '0) begin
        tmr_n = dly;
        pre_n = '0;
      end
      if (cnt == CNT_W'(1)) begin
        ioc_evt = 1'b1;
        cnt_n   = thr;
      end else begin
        cnt_n = cnt - 1'b1;
      end
    end
    if (reload) cnt_n = thr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= CNT_W'(1);
      tmr   <= '0;
      pre_q <= '0;
    end else begin
      cnt   <= cnt_n;
      tmr   <= tmr_n;
      pre_q <= pre_n;
    end
  end
endmodule

// File: rtl/dmac_chan.sv
module dmac_chan
  import dmac_pkg::*;
#(
  parameter int PRESC = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  acc_t        acc,
  input  logic [31:0] wdata,
  input  logic        frame_done,
  input  logic        eng_halt,
  input  logic        eng_idle,
  output logic [31:0] ctrl_o,
  output logic [31:0] stat_o,
  output logic [31:0] cur_o,
  output logic [31:0] tail_o,
  output logic        irq,
  output logic        run,
  output logic        srst
);
  logic [31:0] ctrl_q, ctrl_n, cur_q, cur_n, tail_q, tail_n;
  logic        halt_q, halt_n, idle_q, idle_n;
  logic [2:0]  pend_q, pend_n;
  logic [CNT_W-1:0] cnt, tmr;
  logic        ioc_evt, dly_evt;

  dmac_coalesce #(.PRESC(PRESC), .CNT_W(CNT_W)) u_coal (
    .clk     (clk),
    .rst_n   (rst_n),
    .reload  (acc.wr_ctrl),
    .done    (frame_done),
    .thr     (ctrl_n[23:16]),
    .dly     (ctrl_q[31:24]),
    .cnt     (cnt),
    .tmr     (tmr),
    .ioc_evt (ioc_evt),
    .dly_evt (dly_evt)
  );

  always_comb begin
    ctrl_n = ctrl_q;
    cur_n  = cur_q;
    tail_n = tail_q;
    halt_n = halt_q | eng_halt;
    idle_n = idle_q | eng_idle;
    pend_n = pend_q;
    if (acc.rd_ctrl) ctrl_n[2] = 1'b0;
    if (acc.wr_cur)  cur_n = wdata;
    if (acc.wr_tail) begin
      tail_n = wdata;
      idle_n = 1'b0;
    end
    if (acc.wr_stat) pend_n = pend_q & ~wdata[14:12];
    pend_n = pend_n | {1'b0, dly_evt, ioc_evt};
    if (acc.wr_ctrl) begin
      if (wdata[2] || ctrl_q[2]) begin
        ctrl_n = CTRL_SRST;
        halt_n = 1'b1;
        idle_n = 1'b0;
        pend_n = '0;
      end else begin
        ctrl_n = wdata | 32'h2;
        if (wdata[0]) begin
          halt_n = 1'b0;
          idle_n = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_RST;
      cur_q  <= '0;
      tail_q <= '0;
      halt_q <= 1'b1;
      idle_q <= 1'b0;
      pend_q <= '0;
    end else begin
      ctrl_q <= ctrl_n;
      cur_q  <= cur_n;
      tail_q <= tail_n;
      halt_q <= halt_n;
      idle_q <= idle_n;
      pend_q <= pend_n;
    end
  end

  assign ctrl_o = ctrl_q & ~32'h4;
  assign stat_o = {tmr, cnt, 1'b0, pend_q, 10'b0, idle_q, halt_q};
  assign cur_o  = cur_q;
  assign tail_o = tail_q;
  assign irq    = |(pend_q & ctrl_q[14:12]);
  assign run    = ctrl_q[0];
  assign srst   = ctrl_q[2];
endmodule

// File: rtl/dmac_regs.sv
module dmac_regs
  import dmac_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int PRESC  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [CH_N-1:0]   frame_done,
  input  logic [CH_N-1:0]   eng_halt,
  input  logic [CH_N-1:0]   eng_idle,
  output logic [CH_N-1:0]   irq,
  output logic [CH_N-1:0]   run,
  output logic [CH_N-1:0]   soft_rst,
  output logic              tx_start
);
  localparam logic [ADDR_W-1:0] WIN = ADDR_W'(WIN_BYTES);

  logic [1:0]             rs_q;
  logic                   core_rst_n;
  logic                   sel;
  logic [OFS_W-1:0]       ofs;
  logic                   start_n, start_q;
  logic [CH_N-1:0][31:0]  ctrl_v, stat_v, cur_v, tail_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign core_rst_n = rs_q[1];

  assign sel = 1'((bus_addr / WIN) % ADDR_W'(2));
  assign ofs = OFS_W'(bus_addr % WIN);

  for (genvar c = 0; c < CH_N; c++) begin : g_ch
    acc_t acc;
    logic hit;
    assign hit         = (sel == 1'(c));
    assign acc.wr_ctrl = hit && bus_wr && (ofs == OFS_CTRL);
    assign acc.wr_stat = hit && bus_wr && (ofs == OFS_STAT);
    assign acc.wr_cur  = hit && bus_wr && (ofs == OFS_CUR);
    assign acc.wr_tail = hit && bus_wr && (ofs == OFS_TAIL);
    assign acc.rd_ctrl = hit && bus_rd && (ofs == OFS_CTRL);

    dmac_chan #(.PRESC(PRESC)) u_chan (
      .clk        (clk),
      .rst_n      (core_rst_n),
      .acc        (acc),
      .wdata      (bus_wdata),
      .frame_done (frame_done[c]),
      .eng_halt   (eng_halt[c]),
      .eng_idle   (eng_idle[c]),
      .ctrl_o     (ctrl_v[c]),
      .stat_o     (stat_v[c]),
      .cur_o      (cur_v[c]),
      .tail_o     (tail_v[c]),
      .irq        (irq[c]),
      .run        (run[c]),
      .srst       (soft_rst[c])
    );
  end

  always_comb begin
    case (ofs)
      OFS_CTRL: bus_rdata = ctrl_v[sel];
      OFS_STAT: bus_rdata = stat_v[sel];
      OFS_CUR:  bus_rdata = cur_v[sel];
      OFS_TAIL: bus_rdata = tail_v[sel];
      default:  bus_rdata = '0;
    endcase
  end

  assign start_n = bus_wr && !sel && (ofs == OFS_TAIL);

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) start_q <= 1'b0;
    else             start_q <= start_n;
  end
  assign tx_start = start_q;
endmodule

// File: rtl/dmac_regs_chk.sv
module dmac_regs_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              wr_run,
  input logic              wr_srst,
  input logic [1:0]        eng_halt,
  input logic [1:0]        soft_rst,
  input logic [1:0]        run,
  input logic [1:0]        irq,
  input logic              tx_start,
  input logic [1:0]        halt_v,
  input logic [1:0][2:0]   irq_en
);
  localparam logic [ADDR_W-1:0] PAIR = ADDR_W'(96);

  AST_START_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |-> ($past(bus_wr) && ($past(bus_addr) % PAIR) == ADDR_W'(16))); // R11

  for (genvar c = 0; c < 2; c++) begin : g_c
    localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(c * 48);

    AST_RST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(soft_rst[c]) |-> ($past(bus_rd) && ($past(bus_addr) % PAIR) == CTRL_A)); // R4

    AST_RUN_SRC: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(run[c]) |-> ($past(bus_wr) && $past(wr_run) && ($past(bus_addr) % PAIR) == CTRL_A)); // R2

    AST_IRQ_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
      irq[c] |-> (irq_en[c] != 3'b000)); // R7

    AST_RUN_CLEARS_HALT: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && wr_run && !wr_srst && !soft_rst[c] && !eng_halt[c]
       && (bus_addr % PAIR) == CTRL_A) |=> !halt_v[c]); // R5
  end
endmodule

bind dmac_regs dmac_regs_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_wr   (bus_wr),
  .bus_rd   (bus_rd),
  .bus_addr (bus_addr),
  .wr_run   (bus_wdata[0]),
  .wr_srst  (bus_wdata[2]),
  .eng_halt (eng_halt),
  .soft_rst (soft_rst),
  .run      (run),
  .irq      (irq),
  .tx_start (tx_start),
  .halt_v   ({stat_v[1][0], stat_v[0][0]}),
  .irq_en   ({ctrl_v[1][14:12], ctrl_v[0][14:12]})
);

// File: tb/sim_dmac_regs.sv
`timescale 1ns/1ps
module sim_dmac_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [1:0]  frame_done = '0, eng_halt = '0, eng_idle = '0;
  logic [1:0]  irq, run, soft_rst;
  logic        tx_start;

  int checks = 0;
  int errors = 0;
  bit ended = 1'b0;

  always #2.5 clk = ~clk;

  dmac_regs #(.ADDR_W(8), .PRESC(4)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .frame_done(frame_done), .eng_halt(eng_halt), .eng_idle(eng_idle),
    .irq(irq), .run(run), .soft_rst(soft_rst), .tx_start(tx_start)
  );

  typedef struct packed {
    logic [1:0]  op;    // 0 write, 1 read-check, 2 frame_done, 3 wait
    logic [7:0]  addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic [1:0]  irq;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 38;
  localparam vec_t VT [NV] = '{
    '{2'd1, 8'h00, 32'h0,        32'h0001_0002, 2'b00, 4'd3},  // R3
    '{2'd1, 8'h04, 32'h0,        32'h0001_0001, 2'b00, 4'd3},  // R3
    '{2'd1, 8'h34, 32'h0,        32'h0001_0001, 2'b00, 4'd3},  // R3
    '{2'd0, 8'h00, 32'h0003_1001, 32'h0,        2'b00, 4'd5},  // R5
    '{2'd1, 8'h00, 32'h0,        32'h0003_1003, 2'b00, 4'd2},  // R2
    '{2'd1, 8'h04, 32'h0,        32'h0003_0000, 2'b00, 4'd5},  // R5
    '{2'd2, 8'h00, 32'h1,        32'h0,         2'b00, 4'd8},  // R8
    '{2'd1, 8'h04, 32'h0,        32'h0002_0000, 2'b00, 4'd8},  // R8
    '{2'd2, 8'h00, 32'h1,        32'h0,         2'b00, 4'd8},  // R8
    '{2'd2, 8'h00, 32'h1,        32'h0,         2'b01, 4'd8},  // R8
    '{2'd1, 8'h04, 32'h0,        32'h0003_1000, 2'b01, 4'd8},  // R8
    '{2'd0, 8'h04, 32'h0000_1000, 32'h0,        2'b00, 4'd6},  // R6
    '{2'd1, 8'h04, 32'h0,        32'h0003_0000, 2'b00, 4'd6},  // R6
    '{2'd0, 8'h30, 32'h0000_0001, 32'h0,        2'b00, 4'd1},  // R1
    '{2'd1, 8'h30, 32'h0,        32'h0000_0003, 2'b00, 4'd1},  // R1
    '{2'd1, 8'h60, 32'h0,        32'h0003_1003, 2'b00, 4'd1},  // R1
    '{2'd0, 8'h38, 32'hDEAD_BEE0, 32'h0,        2'b00, 4'd1},  // R1
    '{2'd1, 8'h98, 32'h0,        32'hDEAD_BEE0, 2'b00, 4'd1},  // R1
    '{2'd1, 8'h08, 32'h0,        32'h0000_0000, 2'b00, 4'd1},  // R1
    '{2'd1, 8'h0C, 32'h0,        32'h0000_0000, 2'b00, 4'd1},  // R1
    '{2'd0, 8'h00, 32'h0505_2001, 32'h0,        2'b00, 4'd9},  // R9
    '{2'd2, 8'h00, 32'h1,        32'h0,         2'b00, 4'd9},  // R9
    '{2'd1, 8'h04, 32'h0,        32'h0504_0000, 2'b00, 4'd9},  // R9
    '{2'd3, 8'h00, 32'd30,       32'h0,         2'b01, 4'd9},  // R9
    '{2'd1, 8'h04, 32'h0,        32'h0005_2000, 2'b01, 4'd9},  // R9
    '{2'd0, 8'h04, 32'h0000_2000, 32'h0,        2'b00, 4'd6},  // R6
    '{2'd0, 8'h30, 32'h0001_0001, 32'h0,        2'b00, 4'd7},  // R7
    '{2'd2, 8'h00, 32'h2,        32'h0,         2'b00, 4'd7},  // R7
    '{2'd1, 8'h34, 32'h0,        32'h0001_1000, 2'b00, 4'd7},  // R7
    '{2'd0, 8'h30, 32'h0001_1001, 32'h0,        2'b10, 4'd7},  // R7
    '{2'd0, 8'h34, 32'h0000_0000, 32'h0,        2'b10, 4'd6},  // R6
    '{2'd1, 8'h34, 32'h0,        32'h0001_1000, 2'b10, 4'd6},  // R6
    '{2'd0, 8'h34, 32'h0000_7000, 32'h0,        2'b00, 4'd6},  // R6
    '{2'd0, 8'h00, 32'h0004_0001, 32'h0,        2'b00, 4'd10}, // R10
    '{2'd2, 8'h00, 32'h1,        32'h0,         2'b00, 4'd8},  // R8
    '{2'd1, 8'h04, 32'h0,        32'h0003_0000, 2'b00, 4'd8},  // R8
    '{2'd0, 8'h00, 32'h0004_0001, 32'h0,        2'b00, 4'd10}, // R10
    '{2'd1, 8'h04, 32'h0,        32'h0004_0000, 2'b00, 4'd10}  // R10
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic pulse(input int kind, input logic [1:0] m);
    if (kind == 0) frame_done = m;
    else if (kind == 1) eng_halt = m;
    else eng_idle = m;
    @(negedge clk);
    frame_done = '0; eng_halt = '0; eng_idle = '0;
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R3: outputs after reset
    check("R3", {24'b0, irq, run, soft_rst, tx_start, 1'b0}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d vec%0d", VT[i].req, i);
      case (VT[i].op)
        2'd0: wr(VT[i].addr, VT[i].data);
        2'd1: begin
          rd(VT[i].addr, d);
          check(tag, d, VT[i].exp);
        end
        2'd2: pulse(0, VT[i].data[1:0]);
        default: repeat (VT[i].data) @(negedge clk);
      endcase
      check({tag, " irq"}, {30'b0, irq}, {30'b0, VT[i].irq});
    end

    // R11: channel 0 tail write pulses tx_start for one cycle
    wr(8'h10, 32'h1000);
    check("R11 start", {31'b0, tx_start}, 32'd1);
    @(negedge clk);
    check("R11 one-cycle", {31'b0, tx_start}, 32'd0);
    // R11: channel 1 tail write gives no start
    wr(8'h40, 32'h2000);
    check("R11 ch1 no start", {31'b0, tx_start}, 32'd0);
    rd(8'h40, d);
    check("R1 tail ch1", d, 32'h2000);

    // R12: engine idle, then R11 tail clears idle
    pulse(2, 2'b01);
    rd(8'h04, d);
    check("R12 idle", d, 32'h0004_0002);
    wr(8'h10, 32'h3000);
    rd(8'h04, d);
    check("R11 idle clr", d, 32'h0004_0000);

    // R12: engine halt, then R5 run write clears it
    pulse(1, 2'b01);
    rd(8'h04, d);
    check("R12 halt", d, 32'h0004_0001);
    wr(8'h00, 32'h0004_0001);
    rd(8'h04, d);
    check("R5 halt clr", d, 32'h0004_0000);
    check("R2 run out", {30'b0, run}, 32'd3);

    // R4: soft reset held until control read
    wr(8'h00, 32'h0000_0005);
    check("R4 srst out", {30'b0, soft_rst}, 32'd1);
    check("R4 run low", {31'b0, run[0]}, 32'd0);
    rd(8'h04, d);
    check("R4 status", d, 32'h0001_0001);
    wr(8'h00, 32'h0000_0001);
    check("R4 held run", {31'b0, run[0]}, 32'd0);
    check("R4 held srst", {31'b0, soft_rst[0]}, 32'd1);
    rd(8'h00, d);
    check("R4 ctrl read", d, 32'h0001_0002);
    check("R4 srst clr", {31'b0, soft_rst[0]}, 32'd0);
    wr(8'h00, 32'h0000_0001);
    check("R5 run after", {31'b0, run[0]}, 32'd1);
    rd(8'h04, d);
    check("R5 status", d, 32'h0000_0000);

    // R3: hardware reset in mid-run
    rst_n = 1'b0;
    #1 check("R3 hw reset", {28'b0, run, soft_rst}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    rd(8'h00, d);
    check("R3 ctrl again", d, 32'h0001_0002);
    rd(8'h30, d);
    check("R3 ctrl1 again", d, 32'h0001_0002);

    finish_run();
  end
endmodule